// File: doc/BRIEF.md
# Pipelined ADC Code Corrector

This block is the digital back end of an 8-bit, three-stage pipelined analog-to-digital converter. The three stages hand over raw codes of 3, 3 and 4 bits at staggered moments. The first code is ready at a rising clock edge. The second code follows half a cycle later, on the falling edge. The third code follows another half cycle later, on the next rising edge. The block captures each code at its own edge and lines the three up on a single rising edge. It then merges them into one 8-bit sample and places the sample in an output latch.

The stages overlap by one bit at each of the two inner boundaries. This redundancy lets a later stage absorb a small decision error made by an earlier one. The merge shifts the three codes into place and adds them. It then subtracts a fixed centring offset of 36, and clamps the result to the 8-bit range.

The output latch feeds a bus with an active-high enable. When the enable is low, the data lines read as zero and every per-bit drive enable is low. A pad ring uses these drive enables to float the pins.

Top module: `pipe_adc_corrector`

## Requirements
- R1: The stage-1 code is captured on a rising edge where `st1_valid` is high. The stage-3 code is captured on the next rising edge, when it is aligned with the delayed stage-1 code.
- R2: The merged value is st1·32 + st2·8 + st3 − 36, where st1 is bits [2:0], st2 is bits [2:0] and st3 is bits [3:0], all read as unsigned.
- R3: A merged value below zero gives `dout` = 0x00.
- R4: A merged value above 255 gives `dout` = 0xFF.
- R5: A conversion whose stage-1 code is captured on rising edge T appears on `dout` right after rising edge T+2. That is three rising edges, counting T.
- R6: When no stage-1 code was captured, the output latch keeps its previous value through the matching latch edge.
- R7: When `oe` is low, `dout` reads 0x00 and `dout_drive` reads 0x00. When `oe` is high, `dout_drive` is 0xFF and `dout` shows the latch. `oe` never changes the latch contents.
- R8: After reset, the latch holds 0x00.
- R9: The stage-2 code is captured on the falling edge where `st2_valid` is high. Changes on `st2_code` after that falling edge do not change the conversion's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st1_code | input | 3 | First-stage raw code |
| st1_valid | input | 1 | First-stage strobe, sampled on the rising edge |
| st2_code | input | 3 | Second-stage raw code |
| st2_valid | input | 1 | Second-stage strobe, sampled on the falling edge |
| st3_code | input | 4 | Third-stage raw code, sampled on the rising edge |
| oe | input | 1 | Output enable, active high |
| dout | output | 8 | Corrected sample, 0x00 while disabled |
| dout_drive | output | 8 | Per-bit pad drive enables |

## Verification
The bench feeds codes from an ideal residue model. For each sample the model picks a random value and decomposes it into codes. It sometimes pushes the first-stage decision one step too high or too low, and sometimes moves the second-stage decision down by one. The expected output is the original value, so a wrong shift or a wrong offset shows up as a shifted or scaled sample.

Directed codes at both ends of the range catch a clamp that wraps instead of saturating. The bench leaves gaps in the first-stage strobe, which catches a latch that reloads stale data. It changes the second-stage code right after its falling edge, which catches a design that samples that stage late or on the wrong edge. It toggles the enable, which catches a data bus that leaks while disabled.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  // default code widths of the three pipeline stages and the result
  localparam int unsigned ST1_W_DEF = 3;
  localparam int unsigned ST2_W_DEF = 3;
  localparam int unsigned ST3_W_DEF = 4;
  localparam int unsigned OUT_W_DEF = 8;
endpackage

// File: rtl/stage_align.sv
module stage_align #(
  parameter int unsigned ST1_W = 3,
  parameter int unsigned ST2_W = 3,
  parameter int unsigned ST3_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ST1_W-1:0] st1_code,
  input  logic             st1_valid,
  input  logic [ST2_W-1:0] st2_code,
  input  logic             st2_valid,
  input  logic [ST3_W-1:0] st3_code,
  output logic [ST1_W-1:0] al1,
  output logic [ST2_W-1:0] al2,
  output logic [ST3_W-1:0] al3,
  output logic             al_valid
);
  logic [ST1_W-1:0] s1_q, s1_d;
  logic             v1_q, v1_d;
  logic [ST2_W-1:0] s2_q, s2_d;
  logic [ST1_W-1:0] a1_d;
  logic [ST2_W-1:0] a2_d;
  logic [ST3_W-1:0] a3_d;
  logic             av_d;

  always_comb begin
    s1_d = st1_valid ? st1_code : s1_q;
    v1_d = st1_valid;
    s2_d = st2_valid ? st2_code : s2_q;
    a1_d = v1_q ? s1_q     : al1;
    a2_d = v1_q ? s2_q     : al2;
    a3_d = v1_q ? st3_code : al3;
    av_d = v1_q;
  end

  // rising edge: stage-1 capture and alignment of all three codes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q     <= '0;
      v1_q     <= 1'b0;
      al1      <= '0;
      al2      <= '0;
      al3      <= '0;
      al_valid <= 1'b0;
    end else begin
      s1_q     <= s1_d;
      v1_q     <= v1_d;
      al1      <= a1_d;
      al2      <= a2_d;
      al3      <= a3_d;
      al_valid <= av_d;
    end
  end

  // falling edge: stage-2 capture, half a cycle after stage 1
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) s2_q <= '0;
    else        s2_q <= s2_d;
  end

  // R1
  r1_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |=> (al_valid && al1 == $past(s1_q) && al3 == $past(st3_code)));
  // R9
  r9_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |=> (al2 == $past(s2_q)));
endmodule

// File: rtl/overlap_combiner.sv
module overlap_combiner #(
  parameter int unsigned ST1_W = 3,
  parameter int unsigned ST2_W = 3,
  parameter int unsigned ST3_W = 4,
  parameter int unsigned OUT_W = 8
) (
  input  logic [ST1_W-1:0] al1,
  input  logic [ST2_W-1:0] al2,
  input  logic [ST3_W-1:0] al3,
  output logic [OUT_W-1:0] merged
);
  localparam int unsigned SH2    = ST3_W - 1;
  localparam int unsigned SH1    = SH2 + ST2_W - 1;
  localparam int unsigned OFFSET = (1 << SH1) + (1 << (SH2 - 1));
  localparam int unsigned SUM_W  = OUT_W + 2;

  logic [SUM_W-1:0] w1, w2, w3, acc;

  always_comb begin
    w1  = SUM_W'(al1) << SH1;
    w2  = SUM_W'(al2) << SH2;
    w3  = SUM_W'(al3);
    acc = w1 + w2 + w3 - SUM_W'(OFFSET);
    if (acc[SUM_W-1])
      merged = '0;
    else if (acc[SUM_W-2:OUT_W] != '0)
      merged = '1;
    else
      merged = acc[OUT_W-1:0];
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int unsigned OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [OUT_W-1:0] d,
  input  logic             oe,
  output logic [OUT_W-1:0] dout,
  output logic [OUT_W-1:0] dout_drive
);
  logic [OUT_W-1:0] q, q_d;

  always_comb q_d = ld ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  assign dout       = oe ? q : '0;
  assign dout_drive = {OUT_W{oe}};

  // R5
  r5_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(d)));
  // R6
  r6_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q));
  // R7
  r7_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (dout == '0 && dout_drive == '0));
endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector
  import adc_corr_pkg::*;
#(
  parameter int unsigned ST1_W = ST1_W_DEF,
  parameter int unsigned ST2_W = ST2_W_DEF,
  parameter int unsigned ST3_W = ST3_W_DEF,
  parameter int unsigned OUT_W = OUT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ST1_W-1:0] st1_code,
  input  logic             st1_valid,
  input  logic [ST2_W-1:0] st2_code,
  input  logic             st2_valid,
  input  logic [ST3_W-1:0] st3_code,
  input  logic             oe,
  output logic [OUT_W-1:0] dout,
  output logic [OUT_W-1:0] dout_drive
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [ST1_W-1:0] al1;
  logic [ST2_W-1:0] al2;
  logic [ST3_W-1:0] al3;
  logic             al_valid;
  logic [OUT_W-1:0] merged;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  stage_align #(.ST1_W(ST1_W), .ST2_W(ST2_W), .ST3_W(ST3_W)) u_align (
    .clk(clk), .rst_n(rst_int_n),
    .st1_code(st1_code), .st1_valid(st1_valid),
    .st2_code(st2_code), .st2_valid(st2_valid),
    .st3_code(st3_code),
    .al1(al1), .al2(al2), .al3(al3), .al_valid(al_valid)
  );

  overlap_combiner #(.ST1_W(ST1_W), .ST2_W(ST2_W), .ST3_W(ST3_W), .OUT_W(OUT_W)) u_comb (
    .al1(al1), .al2(al2), .al3(al3), .merged(merged)
  );

  out_stage #(.OUT_W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_int_n), .ld(al_valid), .d(merged), .oe(oe),
    .dout(dout), .dout_drive(dout_drive)
  );

  // R5
  r5_path_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    st1_valid |=> ##1 al_valid);
endmodule

// File: tb/test_pipe_adc_corrector.sv
module test_pipe_adc_corrector;
  localparam int N = 420;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] st1_code, st2_code;
  logic [3:0] st3_code;
  logic       st1_valid, st2_valid, oe;
  logic [7:0] dout, dout_drive;

  int n_chk = 0;
  int n_bad = 0;

  int c1 [0:N+3];
  int c2 [0:N+3];
  int c3 [0:N+3];
  int ev [0:N+3];
  bit vv [0:N+3];

  always #10 clk = ~clk;

  pipe_adc_corrector i_pipe_adc_corrector (
    .clk(clk), .rst_n(rst_n),
    .st1_code(st1_code), .st1_valid(st1_valid),
    .st2_code(st2_code), .st2_valid(st2_valid),
    .st3_code(st3_code), .oe(oe),
    .dout(dout), .dout_drive(dout_drive)
  );

  function automatic int merge_ref(input int a, input int b, input int c);
    int t;
    t = a * 32 + b * 8 + c - 36;
    if (t < 0)   t = 0;
    if (t > 255) t = 255;
    return t;
  endfunction

  // ideal residue model with optional stage-1 / stage-2 decision shifts
  task automatic decompose(input int v, input int esel, input int ksel,
                           output int a, output int b, output int c);
    int r, t;
    a = v >> 5;
    r = v - 32 * a;
    if (esel == 1 && a < 7) begin a = a + 1; r = r - 32; end
    else if (esel == 2 && a > 0 && r <= 3) begin a = a - 1; r = r + 32; end
    t = r + 36;
    b = t >> 3;
    if (b > 7) b = 7;
    c = t - 8 * b;
    if (ksel != 0 && b > 0 && c <= 7) begin b = b - 1; c = c + 8; end
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int model_q;
    int seed;
    int a, b, c, v;
    seed = $urandom(32'h5eed_0a1c);
    rst_n = 1'b0; st1_code = '0; st2_code = '0; st3_code = '0;
    st1_valid = 1'b0; st2_valid = 1'b0; oe = 1'b1;

    // directed corner cases first: R3 / R4 / boundary values
    c1[0] = 0; c2[0] = 0; c3[0] = 0;  ev[0] = 0;   vv[0] = 1; // R3 deep negative
    c1[1] = 1; c2[1] = 0; c3[1] = 3;  ev[1] = 0;   vv[1] = 1; // R3 minus one
    c1[2] = 7; c2[2] = 7; c3[2] = 15; ev[2] = 255; vv[2] = 1; // R4 top
    c1[3] = 7; c2[3] = 7; c3[3] = 12; ev[3] = 255; vv[3] = 1; // R4 just over
    c1[4] = 7; c2[4] = 7; c3[4] = 11; ev[4] = 255; vv[4] = 1; // R2 max exact
    c1[5] = 0; c2[5] = 4; c3[5] = 5;  ev[5] = 1;   vv[5] = 1; // R2 low end
    for (int k = 6; k < N; k++) begin
      v = $urandom_range(0, 255);
      decompose(v, $urandom_range(0, 2), $urandom_range(0, 1), a, b, c);
      c1[k] = a; c2[k] = b; c3[k] = c; ev[k] = v;
      vv[k] = ($urandom_range(0, 5) != 0);
      if (merge_ref(a, b, c) != v) begin
        n_bad++;
        $display("FAIL model R2 actual=%0d expected=%0d", merge_ref(a, b, c), v);
      end
    end
    for (int k = N; k < N + 4; k++) begin
      c1[k] = 0; c2[k] = 0; c3[k] = 0; ev[k] = 0; vv[k] = 0;
    end

    #35;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    check("R8 reset dout", int'(dout), 0);
    check("R7 drive on", int'(dout_drive), 255);
    model_q = 0;

    for (int m = 0; m < N + 4; m++) begin
      @(posedge clk);
      #2;
      st1_code  = 3'(c1[m]);
      st1_valid = vv[m];
      if (m >= 1) begin
        st2_code  = 3'(c2[m-1]);
        st2_valid = vv[m-1];
        st3_code  = 4'(c3[m-1]);
      end
      oe = ($urandom_range(0, 7) != 0);
      #13;
      if (m >= 3 && vv[m-3]) model_q = ev[m-3];
      if (oe) begin
        check("R5 R2 R6 dout", int'(dout), model_q);
        check("R7 drive on", int'(dout_drive), 255);
      end else begin
        check("R7 dout released", int'(dout), 0);
        check("R7 drive off", int'(dout_drive), 0);
      end
      // R9: disturb stage-2 input after its capture edge
      st2_code = 3'($urandom_range(0, 7));
    end

    // R7: latch survives a disabled period
    oe = 1'b1;
    #1;
    check("R7 latch kept", int'(dout), model_q);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule